// File: doc/BRIEF.md
# Input Change Detection Interrupt Unit

This block watches a bank of already-synchronised digital inputs (16 by default). It keeps two sticky status words, one for low-to-high transitions and one for high-to-low transitions, with one bit per input. It also drives a level interrupt towards a host controller whenever an edge of an enabled direction has been recorded and interrupts are globally enabled. Edges are found by comparing each input with a copy of itself delayed by one clock. The first value sampled after reset only primes that copy and never counts as an edge.

The host reads a four-word window with a one-cycle read strobe and a 2-bit address. Each read returns its word on `rd_data` one clock after the strobe, and `rd_data` holds that word until the next read. A small read controller has two states. In `RS_IDLE`, reads return live values. A read of the rising word (offset 0) takes transition `T_CAPTURE`: it returns the rising status, copies the falling status and the current input level into a snapshot, clears both live status words, and enters `RS_HELD`. In `RS_HELD`, reads of the falling word and the data word return the snapshot, so the three words the host sees are coherent. Reading the data word takes transition `T_RELEASE` back to `RS_IDLE`. A further read of offset 0 while in `RS_HELD` takes `T_RECAPTURE`, which captures and clears again. Reads of the reserved word take no transition.

Top module: `edge_watch_irq`

## Requirements
- R1: The window offsets are 0 for rising status, 1 for falling status, 2 for input level and 3 for reserved. A read strobe at one clock edge puts the addressed word on `rd_data` after that edge, and `rd_data` keeps its value while no strobe is given.
- R2: Bit i of every word belongs to input i. In `RS_IDLE`, the level word returns the input values sampled at the clock edge before the read edge.
- R3: A rising-status bit becomes 1 at the clock edge where its input is first sampled at 1 after having been sampled at 0.
- R4: A falling-status bit becomes 1 at the clock edge where its input is first sampled at 0 after having been sampled at 1.
- R5: A status bit, once set, stays set until a read of offset 0 clears it, even if the input returns to its earlier level.
- R6: A read of offset 0 returns the status as it was before the read and clears both status words. Reads of offsets 1 and 2 never clear status.
- R7: An edge detected at the same clock edge as a clearing read stays set after that read.
- R8: After a read of offset 0, reads of offsets 1 and 2 return the falling status and the input level as they stood at that capture. A read of offset 2 returns the controller to live reads, and another read of offset 0 captures again.
- R9: `irq` is high exactly while `cfg_irq_en` is 1 and either `cfg_rise_en` is 1 with some rising bit set, or `cfg_fall_en` is 1 with some falling bit set.
- R10: `irq` falls after a clearing read when no new edge arrives at that read's clock edge.
- R11: A read of offset 3 returns 0, clears nothing and leaves the read state unchanged.
- R12: During and just after reset, `rd_data`, both status words and `irq` are 0. Inputs that are already high when reset ends produce no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | WIDTH | Synchronised inputs to watch |
| cfg_irq_en | input | 1 | Global interrupt enable |
| cfg_rise_en | input | 1 | Rising edges may interrupt |
| cfg_fall_en | input | 1 | Falling edges may interrupt |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_addr | input | 2 | Word offset within the window |
| rd_data | output | WIDTH | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The inputs are driven with these patterns:
- single-bit steps, to check the bit mapping;
- several bits rising and falling in one cycle;
- short pulses on one input, to check that both directions stick at once;
- a walking one across the port, to check that each falling bit follows its neighbour's rising bit.

Edges are placed on the same cycle as a clearing read to show that new events outrank the clear. Reads of the falling and level words are mixed between captures to separate live values from snapshot values. The enable flags are stepped through every combination to show which recorded direction is allowed to drive the interrupt.

// File: rtl/edge_watch_pkg.sv
package edge_watch_pkg;

    localparam int WIN_AW = 2;

    localparam logic [WIN_AW-1:0] OFS_RISE = 2'd0;
    localparam logic [WIN_AW-1:0] OFS_FALL = 2'd1;
    localparam logic [WIN_AW-1:0] OFS_DATA = 2'd2;
    localparam logic [WIN_AW-1:0] OFS_RSVD = 2'd3;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HELD = 1'b1
    } rd_state_e;

endpackage

// File: rtl/edge_detect.sv
module edge_detect #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl_q,
    output logic [WIDTH-1:0] rise_now,
    output logic [WIDTH-1:0] fall_now
);

    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            primed <= 1'b0;
        end else begin
            lvl_q  <= din;
            primed <= 1'b1;
        end
    end

    // The first sample after reset only loads lvl_q.
    always_comb begin
        rise_now = primed ? (din & ~lvl_q) : '0;
        fall_now = primed ? (~din & lvl_q) : '0;
    end

endmodule

// File: rtl/status_bank.sv
module status_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic             clr,
    output logic [WIDTH-1:0] st
);

    // One sticky flag per input. A set in the clearing cycle takes priority.
    for (genvar b = 0; b < WIDTH; b++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st[b] <= 1'b0;
            end else if (set_vec[b]) begin
                st[b] <= 1'b1;
            end else if (clr) begin
                st[b] <= 1'b0;
            end
        end
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((st & $past(set_vec)) == $past(set_vec))); // R3
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (|set_vec)) |=> ((st & $past(set_vec)) == $past(set_vec))); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st & $past(st)) == $past(st))); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((st & ~$past(set_vec)) == '0)); // R6

endmodule

// File: rtl/read_ctrl.sv
module read_ctrl
    import edge_watch_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [WIN_AW-1:0] rd_addr,
    input  logic [WIDTH-1:0]  rise_st,
    input  logic [WIDTH-1:0]  fall_st,
    input  logic [WIDTH-1:0]  lvl_q,
    output logic              clr,
    output logic [WIDTH-1:0]  rd_data
);

    rd_state_e state, state_nx;
    logic [WIDTH-1:0] snap_fall;
    logic [WIDTH-1:0] snap_lvl;

    assign clr = rd_stb && (rd_addr == OFS_RISE);

    // Next-state logic: T_CAPTURE, T_RECAPTURE and T_RELEASE.
    always_comb begin
        state_nx = state;
        if (rd_stb) begin
            unique case (state)
                RS_IDLE: if (rd_addr == OFS_RISE) state_nx = RS_HELD;
                RS_HELD: if (rd_addr == OFS_DATA) state_nx = RS_IDLE;
                default: state_nx = RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    // Outputs: the read word and the snapshot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= '0;
            snap_fall <= '0;
            snap_lvl  <= '0;
        end else if (rd_stb) begin
            unique case (rd_addr)
                OFS_RISE: begin
                    rd_data   <= rise_st;
                    snap_fall <= fall_st;
                    snap_lvl  <= lvl_q;
                end
                OFS_FALL: rd_data <= (state == RS_HELD) ? snap_fall : fall_st;
                OFS_DATA: rd_data <= (state == RS_HELD) ? snap_lvl  : lvl_q;
                OFS_RSVD: rd_data <= '0;
                default:  rd_data <= '0;
            endcase
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == OFS_RSVD) |=> (rd_data == '0)); // R11
    AST_RSVD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == OFS_RSVD) |=> (state == $past(state))); // R11
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == OFS_RISE) |=> (state == RS_HELD)); // R8
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R1

endmodule

// File: rtl/edge_watch_irq.sv
module edge_watch_irq
    import edge_watch_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  din,
    input  logic              cfg_irq_en,
    input  logic              cfg_rise_en,
    input  logic              cfg_fall_en,
    input  logic              rd_stb,
    input  logic [WIN_AW-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              irq
);

    logic [WIDTH-1:0] lvl_q, rise_now, fall_now, rise_st, fall_st;
    logic             clr;

    edge_detect #(.WIDTH(WIDTH)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .lvl_q    (lvl_q),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    status_bank #(.WIDTH(WIDTH)) u_rise_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (rise_now),
        .clr     (clr),
        .st      (rise_st)
    );

    status_bank #(.WIDTH(WIDTH)) u_fall_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (fall_now),
        .clr     (clr),
        .st      (fall_st)
    );

    read_ctrl #(.WIDTH(WIDTH)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .rise_st (rise_st),
        .fall_st (fall_st),
        .lvl_q   (lvl_q),
        .clr     (clr),
        .rd_data (rd_data)
    );

    assign irq = cfg_irq_en & ((cfg_rise_en & (|rise_st)) | (cfg_fall_en & (|fall_st)));

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|rise_st) || (|fall_st))); // R9
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(|rise_now) && !(|fall_now)) |=> !irq); // R10
    AST_EDGE_SETS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_now) |=> (|rise_st)); // R3
    AST_EDGE_SETS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_now) |=> (|fall_st)); // R4

endmodule

// File: tb/test_edge_watch_irq.sv
module test_edge_watch_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = 16'hA5A5;
    logic        cfg_irq_en = 1'b0, cfg_rise_en = 1'b0, cfg_fall_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string phase = "R12 reset";

    always #4 clk = ~clk;

    edge_watch_irq i_edge_watch_irq (
        .clk(clk), .rst_n(rst_n), .din(din),
        .cfg_irq_en(cfg_irq_en), .cfg_rise_en(cfg_rise_en), .cfg_fall_en(cfg_fall_en),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // Behavioural reference model
    logic [15:0] m_prev = '0, m_rise = '0, m_fall = '0;
    logic [15:0] m_snapf = '0, m_snapd = '0, m_rd = '0;
    bit          m_primed = 0, m_held = 0;

    always @(posedge clk) begin
        logic [15:0] rn, fn;
        bit clr;
        if (!rst_n) begin
            m_prev = '0; m_rise = '0; m_fall = '0; m_snapf = '0; m_snapd = '0;
            m_rd = '0; m_primed = 0; m_held = 0;
        end else begin
            rn  = m_primed ? (din & ~m_prev) : 16'h0;
            fn  = m_primed ? (~din & m_prev) : 16'h0;
            clr = 0;
            if (rd_stb) begin
                if (rd_addr == 2'd0) begin
                    m_rd = m_rise; m_snapf = m_fall; m_snapd = m_prev;
                    m_held = 1; clr = 1;
                end else if (rd_addr == 2'd1) begin
                    m_rd = m_held ? m_snapf : m_fall;
                end else if (rd_addr == 2'd2) begin
                    m_rd = m_held ? m_snapd : m_prev;
                    m_held = 0;
                end else begin
                    m_rd = 16'h0;
                end
            end
            m_rise = (clr ? 16'h0 : m_rise) | rn;
            m_fall = (clr ? 16'h0 : m_fall) | fn;
            m_prev = din;
            m_primed = 1;
        end
    end

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    // Compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        logic exp_irq;
        #2;
        exp_irq = cfg_irq_en & ((cfg_rise_en & (|m_rise)) | (cfg_fall_en & (|m_fall)));
        chk("rd_data", rd_data, m_rd);
        chk("irq", {15'h0, irq}, {15'h0, exp_irq});
    end

    task automatic step(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a);
        @(negedge clk); rd_stb = 1'b1; rd_addr = a;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic drive(logic [15:0] v);
        @(negedge clk); din = v;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        phase = "R12 inputs high at reset release";
        step(3);
        cfg_irq_en = 1; cfg_rise_en = 1; cfg_fall_en = 1;
        step(2);

        phase = "R3 R2 single rising bit";
        drive(16'hA5A7); step(2);
        phase = "R1 R6 read rising word";
        rd(2'd0); step(1);
        phase = "R10 irq drops after clear";
        step(2);

        phase = "R4 multiple falling bits";
        drive(16'h0007); step(2);
        phase = "R2 live falling and level reads";
        rd(2'd1); rd(2'd2);
        phase = "R6 falling reads do not clear";
        rd(2'd1);

        phase = "R5 pulse sticks both ways";
        drive(16'h0107); drive(16'h0007); step(3);
        phase = "R8 snapshot sequence";
        rd(2'd0);
        drive(16'hF007);
        rd(2'd1); rd(2'd2);
        phase = "R8 live again after release";
        rd(2'd2); rd(2'd1);

        phase = "R8 recapture while held";
        rd(2'd0); drive(16'h0000); step(1); rd(2'd0); rd(2'd1); rd(2'd2);

        phase = "R7 edge on clearing read";
        @(negedge clk); din = 16'h8001; rd_stb = 1'b1; rd_addr = 2'd0;
        @(negedge clk); rd_stb = 1'b0;
        step(2);
        rd(2'd0);

        phase = "R11 reserved read";
        drive(16'h8003); step(1);
        rd(2'd3); rd(2'd0);
        rd(2'd0); rd(2'd3); rd(2'd1); rd(2'd2);

        phase = "R9 enable combinations";
        drive(16'h8000); step(1);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            cfg_irq_en = c[0]; cfg_rise_en = c[1]; cfg_fall_en = c[2];
            step(1);
        end
        rd(2'd0);
        drive(16'h8001); step(1);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            cfg_irq_en = c[2]; cfg_rise_en = c[0]; cfg_fall_en = c[1];
            step(1);
        end
        cfg_irq_en = 1; cfg_rise_en = 1; cfg_fall_en = 1;
        rd(2'd0);

        phase = "R3 R4 walking one";
        for (int b = 0; b < 16; b++) begin
            drive(16'h1 << b);
            if (b % 4 == 3) begin rd(2'd0); rd(2'd1); rd(2'd2); end
        end
        drive(16'h0); step(2);
        rd(2'd0); rd(2'd1); rd(2'd2);

        phase = "R1 hold between reads";
        step(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule